// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the master side of a four-wire serial link to an eight-input, twelve-bit converter. It runs conversion frames back to back without stopping. Before each frame it waits through a fixed idle gap with the select line high and the serial clock parked high. It then pulls the select line low and issues sixteen serial clock periods. On the falling edges it sends a three-bit input number to the converter. On the rising edges it takes in the converter's answer, most significant bit first.

The serial clock is produced from the block's own clock by a half-period divider. With the default divider of ten, a 50 MHz system clock gives a 2.5 MHz serial clock. The input number is taken from `chan_sel` at the moment the select line falls. When a frame closes, the upper eight of the twelve result bits are written to `conv_value`, and `conv_valid` pulses for one cycle. A display stage drives eight indicator outputs from the stored value. In one mode it copies the value as plain binary. In the other it shows a thermometer bar whose length grows with the value.

Top module: `adc_spi_ctrl`

## Requirements
- R1: While reset is asserted, `sel_n` is 1, `ser_clk` is 1, `cmd_out` is 0, `conv_value` is 0 and `conv_valid` is 0.
- R2: `ser_clk` is high whenever `sel_n` is high. `ser_clk` changes only while `sel_n` is low. Its first falling edge of a frame comes at least one cycle after `sel_n` falls.
- R3: Each frame has exactly 16 falling and 16 rising edges of `ser_clk`, starting with a falling edge. `ser_clk` is high when `sel_n` rises.
- R4: `cmd_out` changes only when `ser_clk` falls. The bit presented for serial clock k (k = 0..15, read at rising edge k) is taken from the word {2'b00, ch[2:0], 11'b0}, MSB first. Clocks 2, 3 and 4 therefore carry ch[2], ch[1] and ch[0], and every other clock carries 0.
- R5: The channel sent in a frame is the value of `chan_sel` sampled in the cycle where `sel_n` falls. Later changes of `chan_sel` take effect only in the next frame.
- R6: `data_in` is sampled on each rising edge of `ser_clk`. The 16 sampled bits form a word, MSB first. The first 4 bits are ignored and the last 12 form the result, whose bits [11:4] become `conv_value`.
- R7: `conv_value` updates, and `conv_valid` is high for exactly one cycle, in the cycle where `sel_n` rises. This happens once per frame, and `conv_value` holds its value at all other times.
- R8: Between two frames, `sel_n` stays high for exactly GAP_CYC (default 20) clock cycles.
- R9: When `disp_bin` is 1, `led` equals `conv_value`.
- R10: When `disp_bin` is 0, `led[i]` is 1 exactly when `conv_value` > 32*i (i = 0..7). A value of 0 lights nothing, and 255 lights all eight.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chan_sel | input | 3 | Converter input number for the next frame |
| disp_bin | input | 1 | Display mode: 1 binary, 0 bar graph |
| data_in | input | 1 | Serial result from the converter |
| sel_n | output | 1 | Active-low converter select |
| ser_clk | output | 1 | Serial clock to the converter, parked high |
| cmd_out | output | 1 | Serial command bits to the converter |
| conv_value | output | 8 | Upper eight bits of the last result |
| conv_valid | output | 1 | One-cycle strobe when `conv_value` is renewed |
| led | output | 8 | Indicator drive, binary or bar graph |

## Verification
Some behaviours are checked by properties on every cycle:
- the parked clock while the select line is high, and the rule that the clock moves only inside a frame;
- the command line changing only with a falling clock;
- the edge count at frame close;
- the single-cycle strobe, and the result holding between strobes;
- the idle-gap counter range;
- the contiguous shape of the bar pattern.

Other behaviours depend on the data and need the bench's scenarios:
- the exact command bits, and the channel latching against mid-frame switch changes;
- the result truncation with random junk in the leading bits;
- the exact gap length;
- the bar thresholds at 0, 1, 32, 33, 128 and 255.

// File: rtl/adc_spi_pkg.sv
`timescale 1ns/1ps
package adc_spi_pkg;

  // Frame sequencer states
  typedef enum logic [1:0] {
    ST_GAP   = 2'd0,  // select high, clock parked, idle gap counting
    ST_SETUP = 2'd1,  // select low, waiting one half period before first fall
    ST_XFER  = 2'd2   // serial clock running
  } seq_state_e;

endpackage

// File: rtl/adc_spi_rst_sync.sv
`timescale 1ns/1ps
module adc_spi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];

endmodule

// File: rtl/adc_spi_halfclk.sv
`timescale 1ns/1ps
module adc_spi_halfclk #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_tick
);

  localparam int CW = $clog2(HALF_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    half_tick = run && (cnt_q == CW'(HALF_DIV - 1));
    cnt_d     = cnt_q;
    if (!run)           cnt_d = '0;
    else if (half_tick) cnt_d = '0;
    else                cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Divider never leaves its range (serial clock period, R3)
  p_div_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(HALF_DIV));

endmodule

// File: rtl/adc_spi_shift.sv
`timescale 1ns/1ps
module adc_spi_shift #(
  parameter int FRAME_BITS = 16,
  parameter int CH_BITS    = 3,
  parameter int CMD_LEAD   = 2,
  parameter int RES_BITS   = 12,
  parameter int OUT_BITS   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [CH_BITS-1:0]  channel,
  input  logic                fall_evt,
  input  logic                rise_evt,
  input  logic                miso,
  output logic                mosi,
  output logic [OUT_BITS-1:0] rx_field
);

  localparam int TAIL = FRAME_BITS - CMD_LEAD - CH_BITS;

  logic [FRAME_BITS-1:0] cmd_q, cmd_d;
  logic [RES_BITS-1:0]   rx_q, rx_d;
  logic                  mosi_q, mosi_d;

  always_comb begin
    cmd_d  = cmd_q;
    mosi_d = mosi_q;
    rx_d   = rx_q;
    if (load) begin
      // channel latched here, when select falls
      cmd_d  = {{(FRAME_BITS-CH_BITS){1'b0}}, channel} << TAIL;
      mosi_d = 1'b0;
    end else if (fall_evt) begin
      mosi_d = cmd_q[FRAME_BITS-1];
      cmd_d  = {cmd_q[FRAME_BITS-2:0], 1'b0};
    end
    if (rise_evt) rx_d = {rx_q[RES_BITS-2:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      mosi_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      cmd_q  <= cmd_d;
      mosi_q <= mosi_d;
      rx_q   <= rx_d;
    end
  end

  assign mosi     = mosi_q;
  assign rx_field = rx_q[RES_BITS-1 -: OUT_BITS];

  // One serial edge at a time, and no load inside a running clock (R3)
  p_edge_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fall_evt && rise_evt) && !(load && (fall_evt || rise_evt)));

endmodule

// File: rtl/adc_led_map.sv
`timescale 1ns/1ps
module adc_led_map #(
  parameter int VAL_BITS = 8,
  parameter int LED_N    = 8
) (
  input  logic [VAL_BITS-1:0] val,
  input  logic                bin_mode,
  output logic [LED_N-1:0]    led
);

  localparam int STEP = (1 << VAL_BITS) / LED_N;

  logic [LED_N-1:0] bar;

  for (genvar i = 0; i < LED_N; i++) begin : g_bar
    assign bar[i] = (val > VAL_BITS'(i * STEP));
  end

  assign led = bin_mode ? LED_N'(val) : bar;

endmodule

// File: rtl/adc_spi_ctrl.sv
`timescale 1ns/1ps
module adc_spi_ctrl
  import adc_spi_pkg::*;
#(
  parameter int HALF_DIV   = 10,
  parameter int GAP_CYC    = 20,
  parameter int FRAME_BITS = 16,
  parameter int CH_BITS    = 3,
  parameter int CMD_LEAD   = 2,
  parameter int RES_BITS   = 12,
  parameter int OUT_BITS   = 8,
  parameter int LED_N      = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CH_BITS-1:0]  chan_sel,
  input  logic                disp_bin,
  input  logic                data_in,
  output logic                sel_n,
  output logic                ser_clk,
  output logic                cmd_out,
  output logic [OUT_BITS-1:0] conv_value,
  output logic                conv_valid,
  output logic [LED_N-1:0]    led
);

  localparam int BW = $clog2(FRAME_BITS + 1);
  localparam int GW = $clog2(GAP_CYC + 1);

  logic                rst_s_n;
  logic                half_tick;
  logic                run;
  logic                load, fall_evt, rise_evt;
  logic [OUT_BITS-1:0] rx_field;

  seq_state_e          state_q, state_d;
  logic                cs_q, cs_d;
  logic                sclk_q, sclk_d;
  logic [BW-1:0]       bit_q, bit_d;
  logic [GW-1:0]       gap_q, gap_d;
  logic [OUT_BITS-1:0] res_q, res_d;
  logic                vld_q, vld_d;

  adc_spi_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  assign run = (state_q != ST_GAP);

  adc_spi_halfclk #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .run       (run),
    .half_tick (half_tick)
  );

  adc_spi_shift #(
    .FRAME_BITS (FRAME_BITS),
    .CH_BITS    (CH_BITS),
    .CMD_LEAD   (CMD_LEAD),
    .RES_BITS   (RES_BITS),
    .OUT_BITS   (OUT_BITS)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (load),
    .channel  (chan_sel),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt),
    .miso     (data_in),
    .mosi     (cmd_out),
    .rx_field (rx_field)
  );

  // Frame sequencer, next state
  always_comb begin
    state_d  = state_q;
    cs_d     = cs_q;
    sclk_d   = sclk_q;
    bit_d    = bit_q;
    gap_d    = gap_q;
    res_d    = res_q;
    vld_d    = 1'b0;
    load     = 1'b0;
    fall_evt = 1'b0;
    rise_evt = 1'b0;
    unique case (state_q)
      ST_GAP: begin
        if (gap_q == GW'(GAP_CYC - 1)) begin
          gap_d   = '0;
          cs_d    = 1'b0;
          load    = 1'b1;
          bit_d   = '0;
          state_d = ST_SETUP;
        end else begin
          gap_d = gap_q + GW'(1);
        end
      end
      ST_SETUP: begin
        if (half_tick) begin
          sclk_d   = 1'b0;
          fall_evt = 1'b1;
          state_d  = ST_XFER;
        end
      end
      ST_XFER: begin
        if (half_tick) begin
          if (!sclk_q) begin
            sclk_d   = 1'b1;
            rise_evt = 1'b1;
            bit_d    = bit_q + BW'(1);
          end else if (bit_q == BW'(FRAME_BITS)) begin
            cs_d    = 1'b1;
            res_d   = rx_field;
            vld_d   = 1'b1;
            state_d = ST_GAP;
          end else begin
            sclk_d   = 1'b0;
            fall_evt = 1'b1;
          end
        end
      end
      default: state_d = ST_GAP;
    endcase
  end

  // Frame sequencer, registers
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_GAP;
      cs_q    <= 1'b1;
      sclk_q  <= 1'b1;
      bit_q   <= '0;
      gap_q   <= '0;
      res_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_d;
      sclk_q  <= sclk_d;
      bit_q   <= bit_d;
      gap_q   <= gap_d;
      res_q   <= res_d;
      vld_q   <= vld_d;
    end
  end

  assign sel_n      = cs_q;
  assign ser_clk    = sclk_q;
  assign conv_value = res_q;
  assign conv_valid = vld_q;

  adc_led_map #(.VAL_BITS(OUT_BITS), .LED_N(LED_N)) u_led (
    .val      (res_q),
    .bin_mode (disp_bin),
    .led      (led)
  );

  // R2: clock parked high outside a frame
  p_park_high_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    sel_n |-> ser_clk);

  // R2: a falling clock needs select already low in the cycle before
  p_select_first_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(ser_clk) |-> $past(!sel_n));

  // R3: frame closes only after all rising edges, with the clock high
  p_frame_len_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(sel_n) |-> (bit_q == BW'(FRAME_BITS)) && ser_clk);

  // R4: command line moves only together with a falling clock
  p_cmd_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    !$stable(cmd_out) |-> $fell(ser_clk));

  // R7: strobe coincides with the end of a frame and lasts one cycle
  p_valid_at_close_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    conv_valid |-> $rose(sel_n));
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    conv_valid |=> !conv_valid);
  p_value_hold_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    !conv_valid |-> $stable(conv_value));

  // R8: gap counter stays inside its window
  p_gap_range_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    gap_q < GW'(GAP_CYC));

  // R10: bar pattern is contiguous from the lowest indicator
  p_bar_thermo_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    !disp_bin |-> ((led & (led + LED_N'(1))) == '0));

endmodule

// File: tb/adc_spi_ctrl_tb.sv
`timescale 1ns/1ps
module adc_spi_ctrl_tb_top;

  localparam int GAP_CYC = 20;
  localparam int NFR     = 150;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] chan_sel;
  logic       disp_bin;
  logic       data_in;
  logic       sel_n, ser_clk, cmd_out, conv_valid;
  logic [7:0] conv_value, led;

  always #10 clk = ~clk;  // 50 MHz

  adc_spi_ctrl dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_sel   (chan_sel),
    .disp_bin   (disp_bin),
    .data_in    (data_in),
    .sel_n      (sel_n),
    .ser_clk    (ser_clk),
    .cmd_out    (cmd_out),
    .conv_value (conv_value),
    .conv_valid (conv_valid),
    .led        (led)
  );

  int   n_chk = 0, n_bad = 0;
  bit   done = 0;
  int   frame_no = 0, frames_done = 0, valid_cnt = 0;
  int   falls, rises, hi_cnt;
  bit   frame_active = 0, have_hi = 0, stray = 0;
  logic [15:0] miso_word, mbits;
  logic [11:0] exp_sample;
  logic [2:0]  exp_ch;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bar expectation: number lit = ceil(v/32), filled from indicator 0
  function automatic logic [7:0] bar_exp(input logic [7:0] v);
    int n = (int'(v) + 31) / 32;
    return 8'((1 << n) - 1);
  endfunction

  function automatic logic [11:0] pick(input int k);
    case (k)
      0:       return 12'h000;
      1:       return 12'hFFF;
      2:       return 12'h01F;  // value 1
      3:       return 12'h200;  // value 32
      4:       return 12'h210;  // value 33
      5:       return 12'h800;  // value 128
      default: return 12'($urandom);
    endcase
  endfunction

  // Converter model and frame monitor
  always @(negedge sel_n) begin
    if (rst_n) begin
      exp_ch     = chan_sel;
      exp_sample = pick(frame_no);
      miso_word  = {4'($urandom), exp_sample};  // junk lead bits (R6)
      falls = 0; rises = 0; mbits = '0; stray = 0;
      chk(ser_clk == 1'b1, "R2 clock high at select fall", int'(ser_clk), 1);
      if (have_hi) chk(hi_cnt == GAP_CYC, "R8 gap length", hi_cnt, GAP_CYC);
      frame_active = 1;
      frame_no++;
    end
  end

  always @(negedge ser_clk) begin
    if (frame_active) begin
      if (falls < 16) data_in = miso_word[15 - falls];
      falls++;
      if (sel_n) stray = 1;
    end
  end

  always @(posedge ser_clk) begin
    if (frame_active) begin
      if (rises < 16) mbits[15 - rises] = cmd_out;
      rises++;
      if (sel_n) stray = 1;
    end
  end

  always @(negedge clk) begin
    if (sel_n && have_hi) hi_cnt++;
  end

  always @(posedge clk) begin
    if (rst_n && conv_valid) valid_cnt++;
  end

  always @(posedge sel_n) begin
    if (frame_active) begin
      frame_active = 0;
      hi_cnt = 0;
      have_hi = 1;
      @(negedge clk);
      chk(rises == 16, "R3 rising edges", rises, 16);
      chk(falls == 16, "R3 falling edges", falls, 16);
      chk(ser_clk == 1'b1, "R3 clock high at close", int'(ser_clk), 1);
      chk(!stray, "R2 clock moved with select high", int'(stray), 0);
      if (chan_sel != exp_ch)
        chk(mbits == {2'b00, exp_ch, 11'b0}, "R5 channel held", int'(mbits), int'({2'b00, exp_ch, 11'b0}));
      else
        chk(mbits == {2'b00, exp_ch, 11'b0}, "R4 command bits", int'(mbits), int'({2'b00, exp_ch, 11'b0}));
      chk(conv_value == exp_sample[11:4], "R6 result", int'(conv_value), int'(exp_sample[11:4]));
      chk(conv_valid == 1'b1, "R7 strobe high", int'(conv_valid), 1);
      if (disp_bin)
        chk(led == exp_sample[11:4], "R9 binary display", int'(led), int'(exp_sample[11:4]));
      else
        chk(led == bar_exp(exp_sample[11:4]), "R10 bar display", int'(led), int'(bar_exp(exp_sample[11:4])));
      @(negedge clk);
      chk(conv_valid == 1'b0, "R7 strobe one cycle", int'(conv_valid), 0);
      frames_done++;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; chan_sel = 3'd7; disp_bin = 1'b0; data_in = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    chk(sel_n == 1'b1, "R1 select", int'(sel_n), 1);
    chk(ser_clk == 1'b1, "R1 clock", int'(ser_clk), 1);
    chk(cmd_out == 1'b0, "R1 command", int'(cmd_out), 0);
    chk(conv_value == 8'd0, "R1 value", int'(conv_value), 0);
    chk(conv_valid == 1'b0, "R1 strobe", int'(conv_valid), 0);
    chk(led == 8'd0, "R1 bar empty", int'(led), 0);
    rst_n = 1'b1;
    while (frames_done < NFR) begin
      @(posedge clk);
      #5;
      if (frame_no < 6) begin
        chan_sel = frame_no[0] ? 3'd0 : 3'd7;
        disp_bin = 1'b0;
      end else if ($urandom % 40 == 0) begin
        chan_sel = 3'($urandom);
        disp_bin = 1'($urandom);
      end
    end
    chk(valid_cnt == frames_done, "R7 one strobe per frame", valid_cnt, frames_done);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog frames=%0d expected=%0d", frames_done, NFR);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule